// File: doc/BRIEF.md
# RAM Self-Clear and Reset Sequencer

This block brings up a set of internal RAMs after every reset. A hardware reset, or a software reset requested by writing a bit in the configuration register, starts a clear pass. The pass writes zero to every word of every RAM. It writes all RAMs in parallel and steps one address per clock. While the pass runs, a read-only busy bit in the configuration register reads 1. The host polls that bit until it drops. Host accesses during the pass are limited to reads of the configuration register and the status register. Any other access is refused and sets a sticky error flag.

Once the pass is over, the RAMs go either to the functional engines or to a test port that the host drives directly. The stop bit in the configuration register makes that choice. The sequencer has three states:
- ST_CLEAR: the pass is running.
- ST_RUN: the engines own the RAMs.
- ST_TEST: the test port owns the RAMs.

The transitions are:
- T_DONE_RUN (ST_CLEAR to ST_RUN): the last address has been written and stop is 0.
- T_DONE_TEST (ST_CLEAR to ST_TEST): the last address has been written and stop is 1.
- T_STOP_ON (ST_RUN to ST_TEST): stop is set.
- T_STOP_OFF (ST_TEST to ST_RUN): stop is cleared.
- T_SRST (ST_RUN or ST_TEST to ST_CLEAR): a software reset is requested.
- Assertion of the hardware reset sends the sequencer to ST_CLEAR from any state and restarts the address counter.

Top module: `ramclr_ctrl`

## Requirements
- R1: While rst_n is low, init_busy, eng_hold and if_idle are 1. After rst_n is released, init_busy stays 1 for exactly DEPTH = 2**ADDR_W rising edges and then falls to 0.
- R2: A clear pass leaves every word of every RAM at zero, and test-port reads afterwards return 0.
- R3: Bit 31 of the configuration register (offset 0x40) reads as the busy state. Bit 0 of the status register (offset 0x44) reads the same state. Straight after a hardware reset, the configuration register reads 0x820000F0.
- R4: While init_busy is 1, only reads of offsets 0x40 and 0x44 return data. Every other access returns read data 0, changes no register and sets status bit 1.
- R5: Status bit 1 is sticky. Outside a clear pass, writing 1 to status bit 1 clears it.
- R6: Outside a clear pass, writing 1 to configuration bit 24 starts a new clear pass. init_busy rises two edges after the write edge and stays 1 for DEPTH rising edges. if_idle is 1 for the same edges. Bit 24 reads 0 once the pass has started.
- R7: Configuration bit 25 is the stop bit and resets to 1. When it is 1 and no pass is running, eng_hold is 1 and the test port owns the RAMs. Test writes are stored, and a test read returns data on the edge after the request. Engine accesses are ignored and eng_rdata is 0.
- R8: When stop is 0 and no pass is running, eng_hold is 0 and the engine port owns the RAMs, with a one-edge read latency. Test-port accesses are ignored and tst_rdata is 0.
- R9: Configuration bits 30:26 and 23:0 read back as written. Writes to unmapped offsets are ignored, and reads of unmapped offsets return 0.
- R10: Host read data appears on the edge after the request edge and is 0 in any cycle that follows no read.
- R11: A hardware reset during a clear pass restarts it, so init_busy lasts DEPTH edges after the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| host_req | input | 1 | Host register access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| init_busy | output | 1 | Clear pass in progress |
| if_idle | output | 1 | Forces the functional interfaces idle |
| eng_hold | output | 1 | Engines denied RAM access |
| eng_en | input | 1 | Engine RAM access strobe |
| eng_we | input | 1 | Engine write |
| eng_sel | input | SEL_W | Engine RAM index |
| eng_addr | input | ADDR_W | Engine RAM address |
| eng_wdata | input | RAM_W | Engine write data |
| eng_rdata | output | RAM_W | Engine read data |
| tst_en | input | 1 | Test-port RAM access strobe |
| tst_we | input | 1 | Test-port write |
| tst_sel | input | SEL_W | Test-port RAM index |
| tst_addr | input | ADDR_W | Test-port RAM address |
| tst_wdata | input | RAM_W | Test-port write data |
| tst_rdata | output | RAM_W | Test-port read data |

## Verification
Register reads, test-port reads and engine reads all return data on the rising edge after the request edge. The bench drives each request at a falling edge and samples at the next falling edge. A software reset written at edge E makes init_busy visible from edge E+2 onward. A monitor counts the rising edges that see init_busy high while reset is released, and the count is compared with DEPTH. Mode changes through the stop bit take effect one edge after the write edge, so the bench leaves two idle cycles before it uses the newly owned port.

// File: rtl/ramclr_pkg.sv
package ramclr_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_RUN   = 2'd1,
        ST_TEST  = 2'd2
    } seq_state_t;

    localparam int          HADDR_W      = 8;
    localparam logic [7:0]  CFG_OFS      = 8'h40;
    localparam logic [7:0]  STAT_OFS     = 8'h44;
    localparam int          CFG_BUSY_BIT = 31;
    localparam int          CFG_STOP_BIT = 25;
    localparam int          CFG_SRST_BIT = 24;
    localparam logic [31:0] CFG_RESET    = 32'h8200_00F0;
    localparam logic [31:0] CFG_WMASK    = 32'h7CFF_FFFF;
    localparam int          STAT_BUSY    = 0;
    localparam int          STAT_ERR     = 1;

endpackage

// File: rtl/ramclr_seq.sv
module ramclr_seq
    import ramclr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_req,
    input  logic              stop,
    output seq_state_t        state,
    output logic [ADDR_W-1:0] cnt,
    output logic              busy,
    output logic              hold,
    output logic              idle
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    seq_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_CLEAR) ? cnt + 1'b1 : '0;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLEAR: if (cnt == LAST) nxt = stop ? ST_TEST : ST_RUN;
            ST_RUN: begin
                if (srst_req)  nxt = ST_CLEAR;
                else if (stop) nxt = ST_TEST;
            end
            ST_TEST: begin
                if (srst_req)   nxt = ST_CLEAR;
                else if (!stop) nxt = ST_RUN;
            end
            default: nxt = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        hold = 1'b1;
        idle = 1'b0;
        unique case (state)
            ST_CLEAR: begin busy = 1'b1; idle = 1'b1; end
            ST_RUN:   hold = 1'b0;
            ST_TEST:  hold = 1'b1;
            default:  hold = 1'b1;
        endcase
    end

endmodule

// File: rtl/ramclr_regs.sv
module ramclr_regs
    import ramclr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               req,
    input  logic               we,
    input  logic [HADDR_W-1:0] addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               stop,
    output logic               srst_req
);
    logic [31:0] cfg_q;
    logic        err_q;
    logic [31:0] rd_val;
    logic        allowed;

    always_comb begin
        unique case (addr)
            CFG_OFS: begin
                rd_val = cfg_q & CFG_WMASK;
                rd_val[CFG_BUSY_BIT] = busy;
                rd_val[CFG_STOP_BIT] = stop;
                rd_val[CFG_SRST_BIT] = srst_req;
            end
            STAT_OFS: begin
                rd_val = '0;
                rd_val[STAT_BUSY] = busy;
                rd_val[STAT_ERR]  = err_q;
            end
            default: rd_val = '0;
        endcase
    end

    assign allowed = !we && ((addr == CFG_OFS) || (addr == STAT_OFS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= CFG_RESET & CFG_WMASK;
            stop     <= CFG_RESET[CFG_STOP_BIT];
            srst_req <= 1'b0;
            err_q    <= 1'b0;
            rdata    <= '0;
        end else begin
            srst_req <= 1'b0;
            rdata    <= '0;
            if (req) begin
                if (busy) begin
                    if (allowed) rdata <= rd_val;
                    else         err_q <= 1'b1;
                end else if (we) begin
                    if (addr == CFG_OFS) begin
                        cfg_q    <= wdata & CFG_WMASK;
                        stop     <= wdata[CFG_STOP_BIT];
                        srst_req <= wdata[CFG_SRST_BIT];
                    end else if (addr == STAT_OFS && wdata[STAT_ERR]) begin
                        err_q <= 1'b0;
                    end
                end else begin
                    rdata <= rd_val;
                end
            end
        end
    end

endmodule

// File: rtl/ramclr_arb.sv
module ramclr_arb
    import ramclr_pkg::*;
#(
    parameter int NUM_RAMS = 2,
    parameter int ADDR_W   = 4,
    parameter int RAM_W    = 16,
    parameter int SEL_W    = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  seq_state_t                       state,
    input  logic [ADDR_W-1:0]                cnt,
    input  logic                             eng_en,
    input  logic                             eng_we,
    input  logic [SEL_W-1:0]                 eng_sel,
    input  logic [ADDR_W-1:0]                eng_addr,
    input  logic [RAM_W-1:0]                 eng_wdata,
    output logic [RAM_W-1:0]                 eng_rdata,
    input  logic                             tst_en,
    input  logic                             tst_we,
    input  logic [SEL_W-1:0]                 tst_sel,
    input  logic [ADDR_W-1:0]                tst_addr,
    input  logic [RAM_W-1:0]                 tst_wdata,
    output logic [RAM_W-1:0]                 tst_rdata,
    output logic [NUM_RAMS-1:0]              ram_en,
    output logic [NUM_RAMS-1:0]              ram_we,
    output logic [NUM_RAMS-1:0][ADDR_W-1:0]  ram_addr,
    output logic [NUM_RAMS-1:0][RAM_W-1:0]   ram_wd,
    input  logic [NUM_RAMS-1:0][RAM_W-1:0]   ram_rd
);
    logic             tst_rd_q, eng_rd_q;
    logic [SEL_W-1:0] tst_sel_q, eng_sel_q;

    for (genvar i = 0; i < NUM_RAMS; i++) begin : g_port
        always_comb begin
            ram_en[i]   = 1'b0;
            ram_we[i]   = 1'b0;
            ram_addr[i] = '0;
            ram_wd[i]   = '0;
            unique case (state)
                ST_CLEAR: begin
                    ram_en[i]   = 1'b1;
                    ram_we[i]   = 1'b1;
                    ram_addr[i] = cnt;
                end
                ST_TEST: begin
                    ram_en[i]   = tst_en && (tst_sel == SEL_W'(i));
                    ram_we[i]   = tst_we;
                    ram_addr[i] = tst_addr;
                    ram_wd[i]   = tst_wdata;
                end
                ST_RUN: begin
                    ram_en[i]   = eng_en && (eng_sel == SEL_W'(i));
                    ram_we[i]   = eng_we;
                    ram_addr[i] = eng_addr;
                    ram_wd[i]   = eng_wdata;
                end
                default: ram_en[i] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tst_rd_q  <= 1'b0;
            eng_rd_q  <= 1'b0;
            tst_sel_q <= '0;
            eng_sel_q <= '0;
        end else begin
            tst_rd_q  <= (state == ST_TEST) && tst_en && !tst_we;
            eng_rd_q  <= (state == ST_RUN) && eng_en && !eng_we;
            tst_sel_q <= tst_sel;
            eng_sel_q <= eng_sel;
        end
    end

    assign tst_rdata = tst_rd_q ? ram_rd[tst_sel_q] : '0;
    assign eng_rdata = eng_rd_q ? ram_rd[eng_sel_q] : '0;

endmodule

// File: rtl/ramclr_ram.sv
module ramclr_ram #(
    parameter int ADDR_W = 4,
    parameter int RAM_W  = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RAM_W-1:0]  wd,
    output logic [RAM_W-1:0]  rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [RAM_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wd;
            else    rd        <= mem[addr];
        end
    end

endmodule

// File: rtl/ramclr_ctrl.sv
module ramclr_ctrl
    import ramclr_pkg::*;
#(
    parameter int NUM_RAMS = 2,
    parameter int ADDR_W   = 4,
    parameter int RAM_W    = 16,
    parameter int SEL_W    = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [7:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              init_busy,
    output logic              if_idle,
    output logic              eng_hold,
    input  logic              eng_en,
    input  logic              eng_we,
    input  logic [SEL_W-1:0]  eng_sel,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [RAM_W-1:0]  eng_wdata,
    output logic [RAM_W-1:0]  eng_rdata,
    input  logic              tst_en,
    input  logic              tst_we,
    input  logic [SEL_W-1:0]  tst_sel,
    input  logic [ADDR_W-1:0] tst_addr,
    input  logic [RAM_W-1:0]  tst_wdata,
    output logic [RAM_W-1:0]  tst_rdata
);
    seq_state_t                      state;
    logic [ADDR_W-1:0]               clr_cnt;
    logic                            stop, srst_req;
    logic [NUM_RAMS-1:0]             ram_en, ram_we;
    logic [NUM_RAMS-1:0][ADDR_W-1:0] ram_addr;
    logic [NUM_RAMS-1:0][RAM_W-1:0]  ram_wd, ram_rd;

    ramclr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .srst_req(srst_req), .stop(stop),
        .state(state), .cnt(clr_cnt), .busy(init_busy), .hold(eng_hold),
        .idle(if_idle)
    );

    ramclr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .busy(init_busy), .req(host_req),
        .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .rdata(host_rdata), .stop(stop), .srst_req(srst_req)
    );

    ramclr_arb #(
        .NUM_RAMS(NUM_RAMS), .ADDR_W(ADDR_W), .RAM_W(RAM_W), .SEL_W(SEL_W)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .state(state), .cnt(clr_cnt),
        .eng_en(eng_en), .eng_we(eng_we), .eng_sel(eng_sel),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
        .tst_en(tst_en), .tst_we(tst_we), .tst_sel(tst_sel),
        .tst_addr(tst_addr), .tst_wdata(tst_wdata), .tst_rdata(tst_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wd(ram_wd), .ram_rd(ram_rd)
    );

    for (genvar i = 0; i < NUM_RAMS; i++) begin : g_ram
        ramclr_ram #(.ADDR_W(ADDR_W), .RAM_W(RAM_W)) u_ram (
            .clk(clk), .en(ram_en[i]), .we(ram_we[i]), .addr(ram_addr[i]),
            .wd(ram_wd[i]), .rd(ram_rd[i])
        );
    end

endmodule

// File: rtl/ramclr_ctrl_chk.sv
module ramclr_ctrl_chk
    import ramclr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int RAM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_busy,
    input logic              eng_hold,
    input logic              host_req,
    input logic              host_we,
    input logic [7:0]        host_addr,
    input logic [31:0]       host_wdata,
    input logic [31:0]       host_rdata,
    input logic              eng_en,
    input logic [RAM_W-1:0]  eng_rdata,
    input logic              tst_en,
    input logic [RAM_W-1:0]  tst_rdata,
    input logic [ADDR_W-1:0] cnt
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && cnt != LAST) |=> (init_busy && cnt == ADDR_W'($past(cnt) + 1'b1))); // R2

    AST_PASS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && cnt == LAST) |=> !init_busy); // R1

    AST_HOLD_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> eng_hold); // R6

    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && host_req && (host_we || (host_addr != CFG_OFS && host_addr != STAT_OFS)))
        |=> host_rdata == '0); // R4

    AST_SRST_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_busy) |-> $past(host_req && host_we && host_addr == CFG_OFS
                                   && host_wdata[CFG_SRST_BIT], 2)); // R6

    AST_TST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_hold && tst_en) |=> tst_rdata == '0); // R8

    AST_ENG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_hold && eng_en) |=> eng_rdata == '0); // R7

endmodule

bind ramclr_ctrl ramclr_ctrl_chk #(.ADDR_W(ADDR_W), .RAM_W(RAM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_busy(init_busy), .eng_hold(eng_hold),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_en(eng_en),
    .eng_rdata(eng_rdata), .tst_en(tst_en), .tst_rdata(tst_rdata),
    .cnt(clr_cnt)
);

// File: tb/ramclr_ctrl_tb.sv
module ramclr_ctrl_tb;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int RAM_W  = 16;
    localparam int NR     = 2;

    logic clk = 0, rst_n = 0;
    logic host_req = 0, host_we = 0;
    logic [7:0] host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic init_busy, if_idle, eng_hold;
    logic eng_en = 0, eng_we = 0, eng_sel = 0;
    logic [ADDR_W-1:0] eng_addr = 0, tst_addr = 0;
    logic [RAM_W-1:0] eng_wdata = 0, eng_rdata, tst_wdata = 0, tst_rdata;
    logic tst_en = 0, tst_we = 0, tst_sel = 0;

    int total = 0, bad = 0, busy_edges = 0, idle_edges = 0;
    logic [31:0] cfg_m;
    logic [RAM_W-1:0] mem_m [NR][DEPTH];
    logic [31:0] r;
    logic [RAM_W-1:0] d;

    always #4 clk = ~clk;

    ramclr_ctrl #(.NUM_RAMS(NR), .ADDR_W(ADDR_W), .RAM_W(RAM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .init_busy(init_busy), .if_idle(if_idle), .eng_hold(eng_hold),
        .eng_en(eng_en), .eng_we(eng_we), .eng_sel(eng_sel), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .tst_en(tst_en),
        .tst_we(tst_we), .tst_sel(tst_sel), .tst_addr(tst_addr),
        .tst_wdata(tst_wdata), .tst_rdata(tst_rdata)
    );

    always @(posedge clk) begin
        if (rst_n && init_busy) busy_edges++;
        if (rst_n && if_idle)   idle_edges++;
    end

    function automatic logic [31:0] exp_cfg(input logic busy);
        return (cfg_m & 32'h7EFF_FFFF) | {busy, 31'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hacc(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        output logic [31:0] rd);
        @(negedge clk);
        host_req = 1; host_we = we; host_addr = a; host_wdata = wd;
        @(negedge clk);
        rd = host_rdata; host_req = 0; host_we = 0;
    endtask

    task automatic tacc(input logic we, input logic s, input logic [ADDR_W-1:0] a,
                        input logic [RAM_W-1:0] wd, output logic [RAM_W-1:0] rd);
        @(negedge clk);
        tst_en = 1; tst_we = we; tst_sel = s; tst_addr = a; tst_wdata = wd;
        @(negedge clk);
        rd = tst_rdata; tst_en = 0; tst_we = 0;
    endtask

    task automatic eacc(input logic we, input logic s, input logic [ADDR_W-1:0] a,
                        input logic [RAM_W-1:0] wd, output logic [RAM_W-1:0] rd);
        @(negedge clk);
        eng_en = 1; eng_we = we; eng_sel = s; eng_addr = a; eng_wdata = wd;
        @(negedge clk);
        rd = eng_rdata; eng_en = 0; eng_we = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && init_busy; i++) @(negedge clk);
    endtask

    task automatic clear_model();
        for (int s = 0; s < NR; s++)
            for (int a = 0; a < DEPTH; a++) mem_m[s][a] = '0;
    endtask

    task automatic check_all_zero(input string req);
        for (int s = 0; s < NR; s++)
            for (int a = 0; a < DEPTH; a++) begin
                tacc(0, s[0], a[ADDR_W-1:0], '0, d);
                chk(req, {16'b0, d}, 32'h0);
            end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        cfg_m = 32'h0200_00F0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'b0, init_busy}, 1);
        chk("R1 hold in reset", {31'b0, eng_hold}, 1);
        chk("R1 idle in reset", {31'b0, if_idle}, 1);
        rst_n = 1;
        #1 busy_edges = 0;
        hacc(0, 8'h40, 0, r);
        chk("R3 cfg reset value", r, 32'h8200_00F0);
        wait_idle();
        chk("R1 busy length", busy_edges, DEPTH);

        hacc(0, 8'h40, 0, r);
        chk("R3 cfg after pass", r, exp_cfg(0));
        hacc(0, 8'h44, 0, r);
        chk("R3 stat after pass", r, 0);
        chk("R7 hold in test", {31'b0, eng_hold}, 1);

        clear_model();
        check_all_zero("R2 hw clear");

        for (int i = 0; i < 40; i++) begin
            logic s; logic [ADDR_W-1:0] a; logic [RAM_W-1:0] w;
            s = $urandom_range(0, 1); a = $urandom_range(0, DEPTH-1);
            w = $urandom_range(0, 65535);
            if ($urandom_range(0, 1)) begin
                tacc(1, s, a, w, d); mem_m[s][a] = w;
            end else begin
                tacc(0, s, a, 0, d);
                chk("R7 test read", {16'b0, d}, {16'b0, mem_m[s][a]});
            end
        end
        eacc(1, 0, 3, 16'hBEEF, d);
        eacc(0, 0, 3, 0, d);
        chk("R7 eng read ignored", {16'b0, d}, 0);
        tacc(0, 0, 3, 0, d);
        chk("R7 eng write ignored", {16'b0, d}, {16'b0, mem_m[0][3]});

        cfg_m = 32'h5C12_3456 & 32'h7CFF_FFFF;
        hacc(1, 8'h40, cfg_m, r);
        repeat (2) @(negedge clk);
        hacc(0, 8'h40, 0, r);
        chk("R9 cfg readback", r, exp_cfg(0));
        chk("R8 hold off", {31'b0, eng_hold}, 0);
        hacc(1, 8'h58, 32'hFFFF_FFFF, r);
        hacc(0, 8'h58, 0, r);
        chk("R9 unmapped read", r, 0);
        hacc(0, 8'h40, 0, r);
        chk("R9 unmapped write ignored", r, exp_cfg(0));
        @(negedge clk);
        chk("R10 rdata idle zero", host_rdata, 0);

        for (int i = 0; i < 40; i++) begin
            logic s; logic [ADDR_W-1:0] a; logic [RAM_W-1:0] w;
            s = $urandom_range(0, 1); a = $urandom_range(0, DEPTH-1);
            w = $urandom_range(0, 65535);
            if ($urandom_range(0, 1)) begin
                eacc(1, s, a, w, d); mem_m[s][a] = w;
            end else begin
                eacc(0, s, a, 0, d);
                chk("R8 eng read", {16'b0, d}, {16'b0, mem_m[s][a]});
            end
        end
        tacc(1, 1, 5, 16'h1234, d);
        tacc(0, 1, 5, 0, d);
        chk("R8 test read ignored", {16'b0, d}, 0);
        eacc(0, 1, 5, 0, d);
        chk("R8 test write ignored", {16'b0, d}, {16'b0, mem_m[1][5]});

        cfg_m = 32'h0200_00A5;
        @(negedge clk);
        busy_edges = 0; idle_edges = 0;
        hacc(1, 8'h40, cfg_m | 32'h0100_0000, r);
        chk("R6 not busy on write edge", {31'b0, init_busy}, 0);
        @(negedge clk);
        chk("R6 busy next", {31'b0, init_busy}, 1);
        hacc(0, 8'h40, 0, r);
        chk("R6 srst reads zero", r, exp_cfg(1));
        hacc(0, 8'h44, 0, r);
        chk("R3 stat busy", r, 1);
        hacc(1, 8'h40, 32'h0000_0000, r);
        chk("R4 write rejected", r, 0);
        hacc(0, 8'h60, 0, r);
        chk("R4 other read rejected", r, 0);
        hacc(0, 8'h44, 0, r);
        chk("R4 err set", r, 3);
        wait_idle();
        chk("R6 busy length", busy_edges, DEPTH);
        chk("R6 idle length", idle_edges, DEPTH);
        hacc(0, 8'h40, 0, r);
        chk("R4 cfg untouched", r, exp_cfg(0));
        hacc(0, 8'h44, 0, r);
        chk("R5 err sticky", r, 2);
        hacc(1, 8'h44, 32'h2, r);
        hacc(0, 8'h44, 0, r);
        chk("R5 err cleared", r, 0);
        repeat (2) @(negedge clk);
        clear_model();
        check_all_zero("R6 srst clear");

        hacc(1, 8'h40, cfg_m | 32'h0100_0000, r);
        repeat (6) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1 busy_edges = 0;
        wait_idle();
        chk("R11 restart length", busy_edges, DEPTH);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule